// File: doc/BRIEF.md
# Word Bus Unaligned Read Sequencer

This block serves a read of one, two or three bytes that falls in IO space behind a bus sixteen bits wide that can only perform word reads. Because a read on that bus may change the state of the device it targets, the sequencer issues exactly as many word reads as the fragment needs: one or two, never more. It gathers the returned words into a 32-bit longword image laid out as an aligned read of the surrounding longword would return it. Picking the addressed bytes out of that image is left to the requester.

A requester pulses `start` with a byte address and a fragment length. The block then runs one or two request/acknowledge reads, the second at the next word address. It ends with a one-cycle `done` pulse and the assembled `rdata`. A successful sequence also raises a one-cycle pulse that asks for the interrupt level to be evaluated again. A bus timeout on any read ends the sequence at once, with an error flag, and issues no further read.

Top module: `wbus_uread_seq`

## Requirements
- R1: A `start` pulse seen while `busy` is low, with `len` nonzero, is accepted. From the next cycle `busy` is high, and `bus_req` is high with `bus_addr` equal to `addr` with bit 0 cleared.
- R2: `len` gives the byte count (1, 2 or 3). When `len + addr[0]` is at most 2, exactly one word read is issued. Otherwise exactly two are issued.
- R3: With one read, the returned word lands in `rdata[31:16]` when `addr[1]` is 1 and in `rdata[15:0]` when it is 0. The other half is zero.
- R4: With two reads, the second targets the first word address plus 2, wrapping within the address width. The result is `{second word, first word}`.
- R5: `bus_req` stays high with `bus_addr` stable until `bus_ack` or `bus_timeout`. After each acknowledge, `bus_req` is low for at least one cycle.
- R6: `done` pulses for one cycle, in the cycle after the final acknowledge, with `rdata` valid and `busy` already low.
- R7: A `start` while `busy` is high, or one with `len` equal to 0, is ignored. It issues no bus read and does not alter the sequence in progress or its result.
- R8: `irq_eval` pulses for one cycle together with each successful `done`, and at no other time.
- R9: A `bus_timeout` on any read aborts the sequence. `done` and `err` pulse together in the next cycle, no further read is issued and `irq_eval` stays low.
- R10: During and after reset, `busy`, `done`, `err`, `irq_eval`, `bus_req` and `rdata` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a fragment read |
| addr | input | ADDR_W | Byte address of the fragment |
| len | input | 2 | Fragment length in bytes (1 to 3; 0 ignored) |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| err | output | 1 | With `done`: the sequence was aborted by a timeout |
| rdata | output | 2*WORD_W | Assembled longword image |
| irq_eval | output | 1 | One-cycle request to evaluate the interrupt level again |
| bus_req | output | 1 | Word read request, held until acknowledge or timeout |
| bus_addr | output | ADDR_W | Even word address of the current read |
| bus_ack | input | 1 | Read acknowledge; `bus_rdata` is valid |
| bus_rdata | input | WORD_W | Word returned by the bus |
| bus_timeout | input | 1 | The current read timed out |

## Verification
The bench builds the block with its defaults: a 22-bit address and a 16-bit word. The 22-bit address lets one case start at the top byte of the space, so the second word address wraps to zero. The bench walks every pairing of length and byte offset, with acknowledge delays from zero to two cycles, so each placement rule meets both immediate and stalled replies. Timeouts are injected on the first and on the second read of a two-read fragment.

// File: rtl/wbur_pkg.sv
// Shared types for the word bus unaligned read sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package wbur_pkg;

    // Controller states: first read, spacer cycle, second read.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD1  = 2'd1,
        ST_GAP  = 2'd2,
        ST_RD2  = 2'd3
    } wbur_state_t;

    // True when a fragment of the given length at the given byte-address
    // parity spills past one bus word.
    function automatic logic needs_two_words(input logic [1:0] nbytes, input logic odd);
        logic [2:0] span;
        span = {1'b0, nbytes} + {2'b00, odd};
        return span > 3'd2;
    endfunction

endpackage

// File: rtl/wbur_plan.sv
// Read planner: decodes a fragment request into the number of word
// reads, the half that a single word occupies, and the first word address.
// Assumes: purely combinational; the caller latches what it needs.
module wbur_plan
    import wbur_pkg::*;
#(
    parameter int ADDR_W = 22
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        len,
    output logic              valid,
    output logic              two,
    output logic              upper,
    output logic [ADDR_W-1:0] waddr
);

    // Decode the request fields.
    always_comb begin
        valid = (len != 2'd0);
        two   = needs_two_words(len, addr[0]);
        upper = addr[1];
        waddr = {addr[ADDR_W-1:1], 1'b0};
    end

endmodule

// File: rtl/wbur_ctrl.sv
// Bus controller: runs one or two request/acknowledge word reads,
// drops the request for one cycle between reads, and ends with done,
// err and irq pulses.
// Assumes: go is only raised while idle; timeout wins over acknowledge.
module wbur_ctrl
    import wbur_pkg::*;
#(
    parameter int ADDR_W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              two_in,
    input  logic [ADDR_W-1:0] waddr_in,
    input  logic              bus_ack,
    input  logic              bus_timeout,
    output logic              bus_req,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              busy,
    output logic              two_q,
    output logic              first_ack,
    output logic              second_ack,
    output logic              done,
    output logic              err,
    output logic              irq_eval
);

    localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(2);

    wbur_state_t st;
    logic        last_ack;
    logic        abort;

    // Classify bus responses for the current state.
    always_comb begin
        bus_req    = (st == ST_RD1) || (st == ST_RD2);
        busy       = (st != ST_IDLE);
        abort      = bus_req && bus_timeout;
        first_ack  = (st == ST_RD1) && bus_ack && !bus_timeout;
        second_ack = (st == ST_RD2) && bus_ack && !bus_timeout;
        last_ack   = (first_ack && !two_q) || second_ack;
    end

    // State register, address and read-count latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            two_q    <= 1'b0;
            bus_addr <= '0;
        end else begin
            case (st)
                ST_IDLE: if (go) begin
                    st       <= ST_RD1;
                    two_q    <= two_in;
                    bus_addr <= waddr_in;
                end
                ST_RD1: if (abort || (first_ack && !two_q)) begin
                    st <= ST_IDLE;
                end else if (first_ack) begin
                    st       <= ST_GAP;
                    bus_addr <= bus_addr + WORD_STEP;
                end
                ST_GAP: st <= ST_RD2;
                ST_RD2: if (abort || second_ack) st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    // End-of-sequence pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done     <= 1'b0;
            err      <= 1'b0;
            irq_eval <= 1'b0;
        end else begin
            done     <= last_ack || abort;
            err      <= abort;
            irq_eval <= last_ack;
        end
    end

endmodule

// File: rtl/wbur_merge.sv
// Result assembler: places returned words into the two halves of the
// longword image according to the read plan.
// Assumes: first_ack and second_ack are exclusive; upper is latched on go.
module wbur_merge #(
    parameter int WORD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                go,
    input  logic                upper_in,
    input  logic                two_q,
    input  logic                first_ack,
    input  logic                second_ack,
    input  logic [WORD_W-1:0]   word,
    output logic [2*WORD_W-1:0] result
);

    localparam int HALVES = 2;

    logic upper_q;

    // Latch the half selector when a sequence starts.
    always_ff @(posedge clk) begin
        if (!rst_n)  upper_q <= 1'b0;
        else if (go) upper_q <= upper_in;
    end

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        logic [WORD_W-1:0] half_q;
        logic              take_first;

        // Decide whether this half receives the first word.
        always_comb begin
            if (h == 0) take_first = two_q || !upper_q;
            else        take_first = !two_q && upper_q;
        end

        // Load or clear this half on each acknowledge.
        always_ff @(posedge clk) begin
            if (!rst_n)
                half_q <= '0;
            else if (first_ack)
                half_q <= take_first ? word : '0;
            else if (second_ack && (h == HALVES - 1))
                half_q <= word;
        end

        assign result[h*WORD_W +: WORD_W] = half_q;
    end

endmodule

// File: rtl/wbus_uread_seq.sv
// Word bus unaligned read sequencer: turns a 1..3 byte IO fragment read
// into the minimum number of word reads and assembles a longword image.
// Assumes: the bus holds bus_rdata valid with bus_ack; requests are
// single-cycle start pulses.
module wbus_uread_seq #(
    parameter int ADDR_W = 22,
    parameter int WORD_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [1:0]          len,
    output logic                busy,
    output logic                done,
    output logic                err,
    output logic [2*WORD_W-1:0] rdata,
    output logic                irq_eval,
    output logic                bus_req,
    output logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_ack,
    input  logic [WORD_W-1:0]   bus_rdata,
    input  logic                bus_timeout
);

    logic              p_valid, p_two, p_upper;
    logic [ADDR_W-1:0] p_waddr;
    logic              go, two_q, first_ack, second_ack;

    wbur_plan #(.ADDR_W(ADDR_W)) plan_i (
        .addr(addr), .len(len), .valid(p_valid), .two(p_two),
        .upper(p_upper), .waddr(p_waddr)
    );

    // Accept a request only when idle and non-empty.
    assign go = start && !busy && p_valid;

    wbur_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .go(go), .two_in(p_two), .waddr_in(p_waddr),
        .bus_ack(bus_ack), .bus_timeout(bus_timeout), .bus_req(bus_req),
        .bus_addr(bus_addr), .busy(busy), .two_q(two_q), .first_ack(first_ack),
        .second_ack(second_ack), .done(done), .err(err), .irq_eval(irq_eval)
    );

    wbur_merge #(.WORD_W(WORD_W)) merge_i (
        .clk(clk), .rst_n(rst_n), .go(go), .upper_in(p_upper), .two_q(two_q),
        .first_ack(first_ack), .second_ack(second_ack), .word(bus_rdata),
        .result(rdata)
    );

endmodule

// File: rtl/wbus_uread_seq_chk.sv
// Protocol checker for the word bus unaligned read sequencer, bound to
// the top module. Assumes: observes ports only.
module wbus_uread_seq_chk #(
    parameter int ADDR_W = 22
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [1:0]        len,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic              irq_eval,
    input logic              bus_req,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_ack,
    input logic              bus_timeout
);

    logic [1:0] nresp;

    // Count bus responses since the last accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            nresp <= 2'd0;
        else if (start && !busy && len != 2'd0)
            nresp <= 2'd0;
        else if (bus_req && (bus_ack || bus_timeout) && nresp != 2'd3)
            nresp <= nresp + 2'd1;
    end

    p_max_two_reads_r2: assert property (@(posedge clk) disable iff (!rst_n)
        nresp <= 2'd2);

    p_req_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack && !bus_timeout) |=> (bus_req && $stable(bus_addr)));

    p_req_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack) |=> !bus_req);

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_req);

    p_irq_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_eval |-> (done && !err));

    p_err_with_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (done && !irq_eval));

endmodule

bind wbus_uread_seq wbus_uread_seq_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .start(start), .len(len), .busy(busy),
    .done(done), .err(err), .irq_eval(irq_eval), .bus_req(bus_req),
    .bus_addr(bus_addr), .bus_ack(bus_ack), .bus_timeout(bus_timeout)
);

// File: tb/wbus_uread_seq_tb_top.sv
module wbus_uread_seq_tb_top;

    localparam int ADDR_W = 22;
    localparam int WORD_W = 16;
    localparam int NVEC   = 12;

    // Vector encoding: {len[1:0], offset[1:0], reads[1:0], upper, spare}
    localparam logic [7:0] VEC [NVEC] = '{
        {2'd1, 2'd0, 2'd1, 1'b0, 1'b0}, {2'd2, 2'd0, 2'd1, 1'b0, 1'b0},
        {2'd3, 2'd0, 2'd2, 1'b0, 1'b0}, {2'd1, 2'd1, 2'd1, 1'b0, 1'b0},
        {2'd2, 2'd1, 2'd2, 1'b0, 1'b0}, {2'd3, 2'd1, 2'd2, 1'b0, 1'b0},
        {2'd1, 2'd2, 2'd1, 1'b1, 1'b0}, {2'd2, 2'd2, 2'd1, 1'b1, 1'b0},
        {2'd3, 2'd2, 2'd2, 1'b0, 1'b0}, {2'd1, 2'd3, 2'd1, 1'b1, 1'b0},
        {2'd2, 2'd3, 2'd2, 1'b0, 1'b0}, {2'd3, 2'd3, 2'd2, 1'b0, 1'b0}
    };

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                start = 1'b0;
    logic [ADDR_W-1:0]   addr_i = '0;
    logic [1:0]          len_i = '0;
    logic                busy, done, err, irq_eval, bus_req;
    logic [2*WORD_W-1:0] rdata;
    logic [ADDR_W-1:0]   bus_addr;
    logic                bus_ack = 1'b0;
    logic                bus_timeout = 1'b0;
    logic [WORD_W-1:0]   bus_rdata = '0;

    int checks = 0;
    int errors = 0;
    int ack_dly = 0;
    int to_idx = 0;
    int nreq = 0;
    int wcnt = 0;
    int gap_viol = 0;
    logic [ADDR_W-1:0] addr_log [4];

    always #2 clk = ~clk;

    wbus_uread_seq #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .addr(addr_i), .len(len_i),
        .busy(busy), .done(done), .err(err), .rdata(rdata), .irq_eval(irq_eval),
        .bus_req(bus_req), .bus_addr(bus_addr), .bus_ack(bus_ack),
        .bus_rdata(bus_rdata), .bus_timeout(bus_timeout)
    );

    function automatic logic [WORD_W-1:0] dword(input logic [ADDR_W-1:0] a);
        return WORD_W'(a) ^ 16'hC3A5;
    endfunction

    // Bus model: replies after ack_dly waiting cycles; timeout on read to_idx.
    always @(negedge clk) begin
        if (!rst_n) begin
            bus_ack = 1'b0; bus_timeout = 1'b0; wcnt = 0;
        end else if (bus_ack || bus_timeout) begin
            if (bus_req) gap_viol++;
            bus_ack = 1'b0; bus_timeout = 1'b0; wcnt = 0;
        end else if (bus_req) begin
            if (wcnt >= ack_dly) begin
                if (nreq < 4) addr_log[nreq] = bus_addr;
                nreq++;
                if (nreq == to_idx) bus_timeout = 1'b1;
                else begin bus_ack = 1'b1; bus_rdata = dword(bus_addr); end
            end else wcnt++;
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    logic g_done, g_err, g_irq, g_busy;
    logic [31:0] g_data;

    task automatic run_op(input logic [ADDR_W-1:0] a, input logic [1:0] l, input int dly, input int toi);
        ack_dly = dly; to_idx = toi; nreq = 0;
        g_done = 0; g_err = 0; g_irq = 0; g_busy = 0; g_data = '0;
        @(negedge clk); start = 1'b1; addr_i = a; len_i = l;
        @(negedge clk); start = 1'b0;
        for (int k = 0; k < 200; k++) begin
            if (done) begin
                g_done = 1; g_err = err; g_irq = irq_eval; g_busy = busy; g_data = rdata;
                break;
            end
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [ADDR_W-1:0] a, w0;
        logic [31:0] expd;
        repeat (3) @(negedge clk);
        // R10: reset state
        check(!busy && !done && !err && !irq_eval && !bus_req && rdata == 0,
              "R10 reset outputs", {busy, done, err, irq_eval, bus_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            logic [1:0] l, off, nr;
            logic up;
            {l, off, nr, up} = VEC[i][7:1];
            a  = ADDR_W'(22'h2F_0000 + i * 8) + ADDR_W'(off);
            w0 = {a[ADDR_W-1:1], 1'b0};
            run_op(a, l, i % 3, 0);
            if (nr == 2) expd = {dword(w0 + 2), dword(w0)};
            else expd = up ? {dword(w0), 16'h0} : {16'h0, dword(w0)};
            check(g_done && !g_err && !g_busy, "R6 done without err, busy low", {g_done, g_err, g_busy}, 3'b100);
            check(nreq == int'(nr), "R2 read count", nreq, nr);
            check(addr_log[0] == w0, "R1 first word address", addr_log[0], w0);
            if (nr == 2) check(addr_log[1] == w0 + 2, "R4 second word address", addr_log[1], w0 + 2);
            check(g_data == expd, nr == 2 ? "R4 two-word result" : "R3 single-word placement", g_data, expd);
            check(g_irq, "R8 irq with done", g_irq, 1);
        end

        // R4: second address wraps at the top of the space
        a = '1;
        run_op(a, 2'd2, 1, 0);
        check(nreq == 2 && addr_log[1] == '0, "R4 wrap address", addr_log[1], 0);
        check(g_data == {dword('0), dword(a - 1)}, "R4 wrap result", g_data, {dword('0), dword(a - 1)});

        // R7: len 0 ignored
        nreq = 0; ack_dly = 0;
        @(negedge clk); start = 1'b1; addr_i = 22'h100; len_i = 2'd0;
        @(negedge clk); start = 1'b0;
        repeat (4) @(negedge clk);
        check(!busy && nreq == 0 && !done, "R7 zero length ignored", nreq, 0);

        // R7: start while busy ignored
        a = 22'h1234; w0 = a;
        ack_dly = 6; to_idx = 0; nreq = 0;
        @(negedge clk); start = 1'b1; addr_i = a; len_i = 2'd2;
        @(negedge clk); addr_i = 22'h0ABD; len_i = 2'd3;
        @(negedge clk); start = 1'b0;
        g_done = 0;
        for (int k = 0; k < 100 && !g_done; k++) begin
            if (done) begin g_done = 1; g_data = rdata; end
            else @(negedge clk);
        end
        repeat (4) @(negedge clk);
        check(nreq == 1 && !busy, "R7 busy start adds no read", nreq, 1);
        check(g_data == {16'h0, dword(w0)}, "R7 busy start keeps result", g_data, {16'h0, dword(w0)});

        // R9: timeout on first of two reads
        run_op(22'h2001, 2'd3, 1, 1);
        repeat (4) @(negedge clk);
        check(g_done && g_err && !g_irq, "R9 timeout first read flags", {g_done, g_err, g_irq}, 3'b110);
        check(nreq == 1, "R9 no read after timeout", nreq, 1);

        // R9: timeout on second read
        run_op(22'h3003, 2'd2, 0, 2);
        check(g_done && g_err && !g_irq && nreq == 2, "R9 timeout second read", {g_done, g_err, g_irq}, 3'b110);

        // R5: request dropped after every acknowledge
        check(gap_viol == 0, "R5 request gap", gap_viol, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule